// File: doc/BRIEF.md
# Dual DAC Serial Write Sequencer

This block sits on the host side of a dual 12-bit voltage-output converter that listens on a three-wire, write-only serial port. The port has an active-low select, a serial clock and a data line. Each transaction is a 16-bit word, shifted out most significant bit first. The converter captures one bit on every falling clock edge. A parallel requester hands the block one command at a time through a valid/ready handshake. The command is one of four: configure the converter (fast settling, power-down, reference choice), load channel A, load channel B, or change both channels at the same instant. The block turns the command into one or two serial words and produces all select, clock and data timing from the system clock.

The word layout is `{sel[1], fast, pdown, sel[0], payload[11:0]}`. The two select bits are split around the speed and power bits. Speed and power are held in the block, and every word carries the held values, so a data write never changes the converter's operating mode by accident. The simultaneous update is sent as two words: first the channel B value goes into the converter's holding buffer, then the channel A word loads A and moves the buffer into B.

The serial half-period is set in system-clock cycles by an input. The block raises it to a safe minimum when needed and latches it when the command is accepted.

Top module: `dac_frame_sequencer`

## Requirements
- R1: Every word is 16 bits, shifted most significant bit first. Data changes only when select falls or when the serial clock rises. Exactly 16 falling clock edges occur while select is low.
- R2: Write-A sends select code 2'b10 with the A value as payload. Write-B sends code 2'b00 with the B value. Configure (op 0) sends code 2'b11 with payload `{10'b0, ref[1:0]}`. Op codes are 0 configure, 1 write-A, 2 write-B, 3 update-both.
- R3: Update-both (op 3) sends two words in order: code 2'b01 carrying the B value, then code 2'b10 carrying the A value.
- R4: Bit 14 carries the fast flag and bit 13 the power-down flag. A configure word carries the requested flags and stores them. Every later data word carries the stored flags. Both flags are 0 after reset.
- R5: Each serial clock high phase and low phase lasts max(div_half, MIN_HALF) system cycles. The value is taken when the command is accepted and holds for all words of that command.
- R6: Select is low for exactly LEAD_CYC cycles, with the clock high, before the first falling edge. The clock never falls while select is high.
- R7: After the 16th falling edge the clock stays low for one half-period, then high for TAIL_CYC cycles with select still low, and only then does select rise. The clock is high whenever select is high.
- R8: Select stays high for GAP_CYC cycles between the two words of an update-both. Ready stays low from acceptance until select has been high for GAP_CYC cycles after the last word.
- R9: After reset, select and clock are high, data is low and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command offered |
| req_ready | output | 1 | Command can be taken this cycle |
| req_op | input | 2 | 0 configure, 1 write A, 2 write B, 3 update both |
| req_code_a | input | 12 | Channel A value |
| req_code_b | input | 12 | Channel B value |
| req_fast | input | 1 | Fast settling flag for configure |
| req_pdown | input | 1 | Power-down flag for configure |
| req_ref | input | 2 | Reference choice for configure |
| div_half | input | DIV_W | Requested serial half-period in system cycles |
| ser_cs_n | output | 1 | Serial select, active low |
| ser_sclk | output | 1 | Serial clock, idles high |
| ser_din | output | 1 | Serial data |

## Verification
The hardest situation to reach is a change of the divider input while a two-word update is still in flight. Only the latched half-period should govern the second word, and the inter-word gap must still be exact. The bench accepts an update-both command with a long half-period and drives the divider to zero on the very next cycle. A protocol monitor then measures every clock phase, the lead, the tail and the gap of both words against the value computed when the command was offered. A sweep over all four commands, several value patterns and divider values below, at and above the minimum also makes the stored speed and power flags reappear in the data words that follow each configure.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

  localparam int FRAME_W = 16;
  localparam int CODE_W  = 12;

  typedef enum logic [1:0] {
    OP_CONFIG      = 2'd0,
    OP_WRITE_A     = 2'd1,
    OP_WRITE_B     = 2'd2,
    OP_UPDATE_BOTH = 2'd3
  } dac_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_TAIL,
    ST_GAP
  } eng_state_e;

  localparam logic [1:0] SEL_B_AND_BUF = 2'b00;
  localparam logic [1:0] SEL_BUF_ONLY  = 2'b01;
  localparam logic [1:0] SEL_A_LOAD_B  = 2'b10;
  localparam logic [1:0] SEL_CONTROL   = 2'b11;

  // Select bits straddle the speed and power flags.
  function automatic logic [FRAME_W-1:0] pack_frame(input logic [1:0] sel,
                                                    input logic fast,
                                                    input logic pdown,
                                                    input logic [CODE_W-1:0] payload);
    return {sel[1], fast, pdown, sel[0], payload};
  endfunction

endpackage

// File: rtl/dacseq_cfg_store.sv
module dacseq_cfg_store (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic fast_in,
  input  logic pdown_in,
  output logic fast_q,
  output logic pdown_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q  <= 1'b0;
      pdown_q <= 1'b0;
    end else if (load) begin
      fast_q  <= fast_in;
      pdown_q <= pdown_in;
    end
  end

endmodule

// File: rtl/dacseq_planner.sv
module dacseq_planner
  import dacseq_pkg::*;
(
  input  dac_op_e             op,
  input  logic [CODE_W-1:0]   code_a,
  input  logic [CODE_W-1:0]   code_b,
  input  logic [1:0]          ref_sel,
  input  logic                fast,
  input  logic                pdown,
  output logic [FRAME_W-1:0]  word_first,
  output logic [FRAME_W-1:0]  word_second,
  output logic                two_frames
);

  localparam int PAD_W = CODE_W - 2;

  always_comb begin
    word_second = pack_frame(SEL_A_LOAD_B, fast, pdown, code_a);
    two_frames  = 1'b0;
    case (op)
      OP_CONFIG:  word_first = pack_frame(SEL_CONTROL, fast, pdown, {{PAD_W{1'b0}}, ref_sel});
      OP_WRITE_A: word_first = pack_frame(SEL_A_LOAD_B, fast, pdown, code_a);
      OP_WRITE_B: word_first = pack_frame(SEL_B_AND_BUF, fast, pdown, code_b);
      default: begin
        word_first = pack_frame(SEL_BUF_ONLY, fast, pdown, code_b);
        two_frames = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/dacseq_serial_engine.sv
module dacseq_serial_engine
  import dacseq_pkg::*;
#(
  parameter int HALF_W   = 8,
  parameter int LEAD_CYC = 2,
  parameter int TAIL_CYC = 2,
  parameter int GAP_CYC  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] start_word,
  input  logic [HALF_W-1:0]  start_half,
  output logic               cs_n,
  output logic               sclk,
  output logic               din,
  output logic               frame_done,
  output logic               last_bit
);

  localparam int FIX_MAX = (LEAD_CYC > TAIL_CYC) ?
                           ((LEAD_CYC > GAP_CYC) ? LEAD_CYC : GAP_CYC) :
                           ((TAIL_CYC > GAP_CYC) ? TAIL_CYC : GAP_CYC);
  localparam int FIX_W   = $clog2(FIX_MAX + 1);
  localparam int CNT_W   = (HALF_W > FIX_W) ? HALF_W : FIX_W;
  localparam int BIT_W   = $clog2(FRAME_W);

  eng_state_e           state;
  logic [CNT_W-1:0]     cnt;
  logic [FRAME_W-1:0]   shreg;
  logic [BIT_W-1:0]     bit_idx;
  logic [HALF_W-1:0]    half_q;
  logic [CNT_W-1:0]     half_m1;
  logic                 phase_end;
  logic                 take;

  assign half_m1    = CNT_W'(half_q) - CNT_W'(1);
  assign phase_end  = (cnt == '0);
  assign frame_done = (state == ST_GAP) && phase_end;
  assign take       = start && ((state == ST_IDLE) || frame_done);
  assign last_bit   = (bit_idx == BIT_W'(FRAME_W - 1));

  assign cs_n = (state == ST_IDLE) || (state == ST_GAP);
  assign sclk = (state != ST_LOW);
  assign din  = !cs_n && shreg[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      bit_idx <= '0;
      half_q  <= '0;
    end else if (take) begin
      state   <= ST_LEAD;
      cnt     <= CNT_W'(LEAD_CYC - 1);
      shreg   <= start_word;
      bit_idx <= '0;
      half_q  <= start_half;
    end else begin
      case (state)
        ST_LEAD: begin
          if (phase_end) begin
            state <= ST_LOW;
            cnt   <= half_m1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_LOW: begin
          if (phase_end) begin
            if (last_bit) begin
              state <= ST_TAIL;
              cnt   <= CNT_W'(TAIL_CYC - 1);
            end else begin
              state   <= ST_HIGH;
              cnt     <= half_m1;
              shreg   <= {shreg[FRAME_W-2:0], 1'b0};
              bit_idx <= bit_idx + 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HIGH: begin
          if (phase_end) begin
            state <= ST_LOW;
            cnt   <= half_m1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_TAIL: begin
          if (phase_end) begin
            state <= ST_GAP;
            cnt   <= CNT_W'(GAP_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GAP: begin
          if (phase_end) begin
            state <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dac_frame_sequencer.sv
module dac_frame_sequencer
  import dacseq_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 3,
  parameter int LEAD_CYC = 2,
  parameter int TAIL_CYC = 2,
  parameter int GAP_CYC  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [11:0]      req_code_a,
  input  logic [11:0]      req_code_b,
  input  logic             req_fast,
  input  logic             req_pdown,
  input  logic [1:0]       req_ref,
  input  logic [DIV_W-1:0] div_half,
  output logic             ser_cs_n,
  output logic             ser_sclk,
  output logic             ser_din
);

  function automatic logic [DIV_W-1:0] clamp_half(input logic [DIV_W-1:0] d);
    return (d < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : d;
  endfunction

  dac_op_e            op_e;
  logic               accept;
  logic               seq_busy;
  logic               pend_q;
  logic [FRAME_W-1:0] second_q;
  logic [DIV_W-1:0]   half_q;
  logic               fast_q, pdown_q;
  logic               fast_eff, pdown_eff;
  logic               is_cfg;
  logic [FRAME_W-1:0] word_first, word_second;
  logic               two_frames;
  logic               eng_start;
  logic [FRAME_W-1:0] eng_word;
  logic [DIV_W-1:0]   eng_half;
  logic               eng_done;
  logic               eng_last_bit;

  assign op_e      = dac_op_e'(req_op);
  assign req_ready = !seq_busy;
  assign accept    = req_valid && req_ready;
  assign is_cfg    = (op_e == OP_CONFIG);
  assign fast_eff  = is_cfg ? req_fast  : fast_q;
  assign pdown_eff = is_cfg ? req_pdown : pdown_q;

  dacseq_cfg_store u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept && is_cfg),
    .fast_in  (req_fast),
    .pdown_in (req_pdown),
    .fast_q   (fast_q),
    .pdown_q  (pdown_q)
  );

  dacseq_planner u_plan (
    .op          (op_e),
    .code_a      (req_code_a),
    .code_b      (req_code_b),
    .ref_sel     (req_ref),
    .fast        (fast_eff),
    .pdown       (pdown_eff),
    .word_first  (word_first),
    .word_second (word_second),
    .two_frames  (two_frames)
  );

  assign eng_start = accept || (eng_done && pend_q);
  assign eng_word  = accept ? word_first : second_q;
  assign eng_half  = accept ? clamp_half(div_half) : half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_busy <= 1'b0;
      pend_q   <= 1'b0;
      second_q <= '0;
      half_q   <= DIV_W'(MIN_HALF);
    end else if (accept) begin
      seq_busy <= 1'b1;
      pend_q   <= two_frames;
      second_q <= word_second;
      half_q   <= clamp_half(div_half);
    end else if (eng_done) begin
      if (pend_q) pend_q <= 1'b0;
      else        seq_busy <= 1'b0;
    end
  end

  dacseq_serial_engine #(
    .HALF_W   (DIV_W),
    .LEAD_CYC (LEAD_CYC),
    .TAIL_CYC (TAIL_CYC),
    .GAP_CYC  (GAP_CYC)
  ) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (eng_start),
    .start_word (eng_word),
    .start_half (eng_half),
    .cs_n       (ser_cs_n),
    .sclk       (ser_sclk),
    .din        (ser_din),
    .frame_done (eng_done),
    .last_bit   (eng_last_bit)
  );

endmodule

// File: rtl/dacseq_checker.sv
module dacseq_checker (
  input logic clk,
  input logic rst_n,
  input logic ser_cs_n,
  input logic ser_sclk,
  input logic ser_din,
  input logic req_ready,
  input logic last_bit
);

  logic [4:0] fall_cnt;
  logic       sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_cnt <= '0;
      sclk_d   <= 1'b1;
    end else begin
      sclk_d <= ser_sclk;
      if (ser_cs_n)                 fall_cnt <= '0;
      else if (sclk_d && !ser_sclk) fall_cnt <= fall_cnt + 1'b1;
    end
  end

  // R7
  clk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_cs_n |-> ser_sclk);

  // R8
  busy_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_cs_n |-> !req_ready);

  // R1
  din_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_cs_n && !$past(ser_cs_n) && !$rose(ser_sclk)) |-> $stable(ser_din));

  // R1
  sixteen_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_cs_n) |-> (fall_cnt == 5'd16));

  // R6
  fall_only_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_sclk) |-> !ser_cs_n);

  // R7
  release_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_cs_n) |-> ($past(ser_sclk) && $past(last_bit)));

endmodule

bind dac_frame_sequencer dacseq_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_cs_n  (ser_cs_n),
  .ser_sclk  (ser_sclk),
  .ser_din   (ser_din),
  .req_ready (req_ready),
  .last_bit  (eng_last_bit)
);

// File: tb/dac_frame_sequencer_tb.sv
`timescale 1ns/1ps
module dac_frame_sequencer_tb;

  localparam int DIV_W    = 8;
  localparam int MIN_HALF = 3;
  localparam int LEAD_CYC = 2;
  localparam int TAIL_CYC = 2;
  localparam int GAP_CYC  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0;
  logic [11:0] req_code_a = '0, req_code_b = '0;
  logic req_fast = 1'b0, req_pdown = 1'b0;
  logic [1:0] req_ref = '0;
  logic [DIV_W-1:0] div_half = '0;
  logic ser_cs_n, ser_sclk, ser_din;

  always #5 clk = ~clk;

  dac_frame_sequencer #(
    .DIV_W(DIV_W), .MIN_HALF(MIN_HALF), .LEAD_CYC(LEAD_CYC),
    .TAIL_CYC(TAIL_CYC), .GAP_CYC(GAP_CYC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_code_a(req_code_a), .req_code_b(req_code_b),
    .req_fast(req_fast), .req_pdown(req_pdown), .req_ref(req_ref),
    .div_half(div_half), .ser_cs_n(ser_cs_n), .ser_sclk(ser_sclk), .ser_din(ser_din)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // expected frame stream
  int exp_q[$];
  string tag_q[$];
  int exp_h = MIN_HALF;
  bit fast_m = 0, pd_m = 0;

  function automatic int mk(input int sel, input bit f, input bit p, input int pl);
    return (sel / 2) * 32768 + f * 16384 + p * 8192 + (sel % 2) * 4096 + pl;
  endfunction

  function automatic logic [11:0] pat(input int k);
    case (k)
      0: return 12'h000;
      1: return 12'hFFF;
      2: return 12'hA5C;
      default: return 12'h3C1;
    endcase
  endfunction

  // serial monitor
  bit prev_cs = 1, prev_sclk = 1, prev_rdy = 1;
  int run = 0, nbits = 0, lead_w = 0, width_err = 0, rdy_err = 0;
  int gap_run = 0, seq_frames = 0;
  logic [15:0] word = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ser_cs_n) begin
        if (prev_cs) begin
          if (seq_frames > 0) chk(gap_run == GAP_CYC, "R8 gap between words", gap_run, GAP_CYC);
          nbits = 0; word = '0; run = 1; lead_w = 0; width_err = 0; rdy_err = 0;
        end else if (ser_sclk != prev_sclk) begin
          if (prev_sclk) begin
            if (nbits == 0) lead_w = run;
            else if (run != exp_h) width_err++;
          end else if (run != exp_h) width_err++;
          if (!ser_sclk) begin
            word = {word[14:0], ser_din};
            nbits++;
          end
          run = 1;
        end else begin
          run++;
        end
        if (req_ready) rdy_err++;
      end else begin
        if (!prev_cs) begin
          chk(nbits == 16, "R1 falling edges per word", nbits, 16);
          if (exp_q.size() == 0) begin
            chk(0, "R3 unexpected word", word, 0);
          end else begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(word == 16'(e), t, word, e);
          end
          chk(width_err == 0, "R5 clock phase width", width_err, 0);
          chk(lead_w == LEAD_CYC, "R6 select lead", lead_w, LEAD_CYC);
          chk(prev_sclk && run == TAIL_CYC, "R7 tail before release", run, TAIL_CYC);
          chk(rdy_err == 0, "R8 ready low during word", rdy_err, 0);
          seq_frames++;
          gap_run = 1;
        end else if (!req_ready) begin
          gap_run++;
        end
        if (req_ready && !prev_rdy && seq_frames > 0)
          chk(gap_run == GAP_CYC, "R8 idle before ready", gap_run, GAP_CYC);
      end
      prev_cs = ser_cs_n; prev_sclk = ser_sclk; prev_rdy = req_ready;
    end
  end

  task automatic send(input int op, input logic [11:0] a, input logic [11:0] b,
                      input bit f, input bit p, input logic [1:0] rf,
                      input int div, input int div_after);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    exp_h = (div < MIN_HALF) ? MIN_HALF : div;
    seq_frames = 0;
    case (op)
      0: begin
        fast_m = f; pd_m = p;
        exp_q.push_back(mk(3, f, p, rf)); tag_q.push_back("R2 R4 configure word");
      end
      1: begin exp_q.push_back(mk(2, fast_m, pd_m, a)); tag_q.push_back("R2 R4 write-A word"); end
      2: begin exp_q.push_back(mk(0, fast_m, pd_m, b)); tag_q.push_back("R2 R4 write-B word"); end
      default: begin
        exp_q.push_back(mk(1, fast_m, pd_m, b)); tag_q.push_back("R3 buffer word");
        exp_q.push_back(mk(2, fast_m, pd_m, a)); tag_q.push_back("R3 A-and-load word");
      end
    endcase
    req_op = 2'(op); req_code_a = a; req_code_b = b;
    req_fast = f; req_pdown = p; req_ref = rf; div_half = DIV_W'(div);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    div_half = DIV_W'(div_after);
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R3 words left unsent", exp_q.size(), 0);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int divs[4];
    divs = '{0, 2, 3, 5};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9
    chk(ser_cs_n == 1'b1, "R9 select after reset", ser_cs_n, 1);
    chk(ser_sclk == 1'b1, "R9 clock after reset", ser_sclk, 1);
    chk(ser_din == 1'b0, "R9 data after reset", ser_din, 0);
    chk(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);
    // R4: data word before any configure carries zero flags
    send(1, 12'h7E1, 12'h000, 1, 1, 2'b00, 3, 3);
    foreach (divs[d]) begin
      for (int op = 0; op < 4; op++) begin
        for (int k = 0; k < 4; k++) begin
          send(op, pat(k), pat(k) ^ 12'h6B7, k[0], k[1], 2'(k), divs[d], divs[d]);
        end
      end
    end
    // R5: divider changed right after acceptance of a two-word command
    send(3, 12'h9A4, 12'h1F0, 0, 0, 2'b00, 6, 0);
    send(0, 12'h000, 12'h000, 1, 0, 2'b10, 1, 7);
    send(3, 12'hFFF, 12'h001, 0, 0, 2'b00, 4, 1);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule